// File: doc/BRIEF.md
# 24-bit Effective Address Generator

This block turns an addressing-mode code, the instruction's operand bytes and the processor's base and index registers into the 24-bit address of an operand. Modes that need no memory lookup (direct page, direct page indexed by X, absolute long, absolute long indexed by X, stack relative) finish one clock after the request. Indirect modes first read a 2-byte or 3-byte little-endian pointer from bank zero, one byte per cycle. Each byte is requested on `rd_req`/`rd_addr` and accepted when `rd_valid` is high. The pointer is then merged with the data bank or used as a full 24-bit address, and Y is optionally added.

A request is a one-cycle `start` while the block is idle. The result appears on `ea` together with a one-cycle `done`. `ea` holds its value until the next result. The index registers are taken as 16-bit values. Narrowing them for 8-bit index mode is the caller's job.

Top module: `ea_gen24`

## Requirements
- R1: Mode 0 (direct page): ea = {8'h00, (base + opnd[7:0]) mod 2^16}, where base is `dpage`.
- R2: Mode 1 (direct page indexed): ea = {8'h00, (dpage + opnd[7:0] + xidx) mod 2^16}. The sum wraps inside bank zero.
- R3: Mode 2 (direct page indirect): a 2-byte pointer is read at dpage+opnd[7:0]. ea = {dbank, pointer}.
- R4: Mode 3 (direct page indirect long): a 3-byte pointer is read at dpage+opnd[7:0], low byte first. That pointer is the ea.
- R5: Mode 4 (direct page indirect long, Y-indexed): ea = (3-byte pointer + yidx) mod 2^24. The carry propagates into bits 23:16.
- R6: Mode 5 (absolute long): ea = opnd[23:0].
- R7: Mode 6 (absolute long, X-indexed): ea = (opnd + xidx) mod 2^24. The carry propagates into bits 23:16.
- R8: Mode 7 (stack relative): ea = {8'h00, (sp + opnd[7:0]) mod 2^16}.
- R9: Mode 8 (stack relative indirect, Y-indexed): a 2-byte pointer is read at sp+opnd[7:0]. ea = ({dbank, pointer} + yidx) mod 2^24.
- R10: Pointer bytes are requested in order, low byte first. Byte k is requested at {8'h00, (base+opnd[7:0]+k) mod 2^16}. `rd_req` and `rd_addr` hold until `rd_valid`. The byte on `rd_data` is taken in that same cycle.
- R11: `done` is high for one cycle, exactly one clock after a direct request or after the last pointer byte is accepted. `ea` changes only together with `done`. A `start` received while a pointer fetch is in progress has no effect.
- R12: After reset, `done` and `rd_req` are low and `ea` is zero.
- R13: Mode codes 9 to 15 behave as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when idle |
| mode | input | 4 | Addressing-mode code |
| opnd | input | 24 | Operand bytes, low byte first |
| dpage | input | 16 | Direct page base |
| dbank | input | 8 | Data bank |
| sp | input | 16 | Stack pointer |
| xidx | input | 16 | X index |
| yidx | input | 16 | Y index |
| rd_req | output | 1 | Pointer byte read request |
| rd_addr | output | 24 | Pointer byte address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 8 | Read data byte |
| ea | output | 24 | Effective address |
| done | output | 1 | Result strobe |

## Verification
The assertions check on every cycle that pointer reads stay in bank zero and hold steady while stalled. They also check that each accepted byte advances the address by one, that `ea` moves only with `done`, and that `done` never overlaps a read. The arithmetic of each mode can only be shown by the bench's scenarios. These include wrap of direct page sums in bank zero, carry into the bank from X or Y, and the bank choice between DBR and a fetched byte. The same applies to ignoring `start` during a fetch, since that needs a reference computed at the ports.

// File: rtl/ea_gen24.sv
module ea_gen24 #(
  parameter int AW = 24,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [AW-1:0] opnd,
  input  logic [RW-1:0] dpage,
  input  logic [7:0]    dbank,
  input  logic [RW-1:0] sp,
  input  logic [RW-1:0] xidx,
  input  logic [RW-1:0] yidx,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] ea,
  output logic          done
);
  localparam logic [3:0] M_DPI = 4'd2, M_DPL = 4'd3, M_DPLY = 4'd4, M_ABL = 4'd5,
                         M_ABLX = 4'd6, M_SR = 4'd7, M_SRIY = 4'd8, M_DPX = 4'd1;
  localparam int BW = AW - RW;

  logic          busy;
  logic [1:0]    idx, last;
  logic [3:0]    mode_q;
  logic [RW-1:0] base_q, y_q;
  logic [7:0]    bank_q;
  logic [AW-1:0] ptr_q, ptr_n, fin;
  logic [RW-1:0] dp_sum, sr_sum, base_n;
  logic          is_ptr;

  assign dp_sum = dpage + RW'(opnd[7:0]);
  assign sr_sum = sp + RW'(opnd[7:0]);
  assign is_ptr = (mode == M_DPI) || (mode == M_DPL) || (mode == M_DPLY) || (mode == M_SRIY);
  assign base_n = (mode == M_SRIY) ? sr_sum : dp_sum;

  assign rd_req  = busy;
  assign rd_addr = {{BW{1'b0}}, base_q + RW'(idx)};

  always_comb begin
    ptr_n = ptr_q;
    case (idx)
      2'd0:    ptr_n[7:0]   = rd_data;
      2'd1:    ptr_n[15:8]  = rd_data;
      default: ptr_n[23:16] = rd_data;
    endcase
    case (mode_q)
      M_DPL:   fin = ptr_n;
      M_DPLY:  fin = ptr_n + AW'(y_q);
      M_SRIY:  fin = {bank_q, ptr_n[RW-1:0]} + AW'(y_q);
      default: fin = {bank_q, ptr_n[RW-1:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; idx <= '0; last <= '0; mode_q <= '0; base_q <= '0;
      y_q <= '0; bank_q <= '0; ptr_q <= '0; ea <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (rd_valid) begin
          ptr_q <= ptr_n;
          if (idx == last) begin
            busy <= 1'b0;
            ea   <= fin;
            done <= 1'b1;
          end else begin
            idx <= idx + 2'd1;
          end
        end
      end else if (start) begin
        if (is_ptr) begin
          busy   <= 1'b1;
          idx    <= '0;
          last   <= (mode == M_DPL || mode == M_DPLY) ? 2'd2 : 2'd1;
          mode_q <= mode;
          base_q <= base_n;
          y_q    <= yidx;
          bank_q <= dbank;
        end else begin
          done <= 1'b1;
          case (mode)
            M_DPX:   ea <= {{BW{1'b0}}, dp_sum + xidx};
            M_ABL:   ea <= opnd;
            M_ABLX:  ea <= opnd + AW'(xidx);
            M_SR:    ea <= {{BW{1'b0}}, sr_sum};
            default: ea <= {{BW{1'b0}}, dp_sum};
          endcase
        end
      end
    end
  end
endmodule

module ea_gen24_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic        rd_valid,
  input logic [23:0] rd_addr,
  input logic [23:0] ea,
  input logic        done
);
  p_req_bank0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[23:16] == 8'h00);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr));
  p_addr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_valid |=> !rd_req || rd_addr[15:0] == $past(rd_addr[15:0]) + 16'd1);
  p_ea_moves_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ea) |-> done);
  p_done_no_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);
endmodule

bind ea_gen24 ea_gen24_chk u_chk (.*);

// File: tb/tb_ea_gen24.sv
module tb_ea_gen24;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd_valid = 1'b0;
  logic [3:0]  mode = '0;
  logic [23:0] opnd = '0;
  logic [15:0] dpage = '0, sp = '0, xidx = '0, yidx = '0;
  logic [7:0]  dbank = '0, rd_data;
  logic        rd_req, done;
  logic [23:0] rd_addr, ea;
  int vecs = 0, errs = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] memb(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction
  assign rd_data = memb(rd_addr);

  ea_gen24 dut (.*);

  function automatic string tag(input logic [3:0] m);
    case (m)
      4'd0: return "R1"; 4'd1: return "R2"; 4'd2: return "R3"; 4'd3: return "R4";
      4'd4: return "R5"; 4'd5: return "R6"; 4'd6: return "R7"; 4'd7: return "R8";
      4'd8: return "R9"; default: return "R13";
    endcase
  endfunction

  // reference model state
  bit          m_busy = 0, x_done = 0;
  int          m_cnt, m_last;
  logic [15:0] m_base, m_y;
  logic [7:0]  m_bank;
  logic [3:0]  m_mode, last_mode = '0;
  logic [7:0]  m_b [3];
  logic [23:0] x_ea = '0;

  task automatic chk(input bit ok, input string r, input logic [23:0] act, input logic [23:0] exp);
    vecs++;
    if (!ok) begin errs++; $display("FAIL %s actual=%h expected=%h", r, act, exp); end
  endtask

  task automatic compare();
    logic [23:0] xa;
    xa = {8'h00, m_base + 16'(m_cnt)};
    chk(done === x_done, "R11 done", {23'd0, done}, {23'd0, x_done});
    chk(ea === x_ea, tag(last_mode), ea, x_ea);
    chk(rd_req === m_busy, "R10 rd_req", {23'd0, rd_req}, {23'd0, m_busy});
    if (m_busy) chk(rd_addr === xa, "R10 rd_addr", rd_addr, xa);
  endtask

  task automatic model_step();
    logic [23:0] p;
    x_done = 0;
    if (m_busy) begin
      if (rd_valid) begin
        m_b[m_cnt] = memb({8'h00, m_base + 16'(m_cnt)});
        if (m_cnt == m_last) begin
          m_busy = 0; x_done = 1; last_mode = m_mode;
          p = {m_b[2], m_b[1], m_b[0]};
          case (m_mode)
            4'd2: x_ea = {m_bank, p[15:0]};
            4'd3: x_ea = p;
            4'd4: x_ea = p + {8'h00, m_y};
            default: x_ea = {m_bank, p[15:0]} + {8'h00, m_y};
          endcase
        end else m_cnt++;
      end
    end else if (start) begin
      if (mode inside {4'd2, 4'd3, 4'd4, 4'd8}) begin
        m_busy = 1; m_cnt = 0; m_mode = mode; m_y = yidx; m_bank = dbank;
        m_last = (mode == 4'd3 || mode == 4'd4) ? 2 : 1;
        m_base = (mode == 4'd8) ? sp + {8'h00, opnd[7:0]} : dpage + {8'h00, opnd[7:0]};
        m_b[2] = 8'h00;
      end else begin
        x_done = 1; last_mode = mode;
        case (mode)
          4'd1: x_ea = {8'h00, dpage + {8'h00, opnd[7:0]} + xidx};
          4'd5: x_ea = opnd;
          4'd6: x_ea = opnd + {8'h00, xidx};
          4'd7: x_ea = {8'h00, sp + {8'h00, opnd[7:0]}};
          default: x_ea = {8'h00, dpage + {8'h00, opnd[7:0]}};
        endcase
      end
    end
  endtask

  // one cycle: compare settled outputs, drive new inputs, advance model
  task automatic cyc(input bit s, input logic [3:0] m, input logic [23:0] o,
                     input logic [15:0] d, input logic [15:0] x, input logic [15:0] y,
                     input logic [15:0] st, input logic [7:0] b, input bit v);
    @(negedge clk);
    compare();
    start = s; mode = m; opnd = o; dpage = d; xidx = x; yidx = y; sp = st; dbank = b; rd_valid = v;
    model_step();
  endtask

  task automatic run(input logic [3:0] m, input logic [23:0] o, input logic [15:0] d,
                     input logic [15:0] x, input logic [15:0] y, input logic [15:0] st, input logic [7:0] b);
    cyc(1, m, o, d, x, y, st, b, 0);
    for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(done === 1'b0 && rd_req === 1'b0, "R12 ctrl", {22'd0, done, rd_req}, 24'd0);
    chk(ea === 24'd0, "R12 ea", ea, 24'd0);
    rst_n = 1'b1;
    run(4'd0, 24'h000080, 16'h0300, 0, 0, 0, 8'h7E);        // R1 -> 000380
    run(4'd1, 24'h000020, 16'hFFF0, 16'h0001, 0, 0, 8'h7E); // R2 wraps in bank 0
    run(4'd2, 24'h000081, 16'h0300, 0, 0, 0, 8'h12);        // R3
    run(4'd3, 24'h000081, 16'h0300, 0, 0, 0, 8'h12);        // R4
    run(4'd4, 24'h0000FF, 16'hFFFF, 0, 16'hFFFF, 0, 8'h12); // R5 carry, R10 wrap
    run(4'd5, 24'h030201, 0, 0, 0, 0, 8'h12);               // R6
    run(4'd6, 24'h01FFFF, 0, 16'h0002, 0, 0, 8'h12);        // R7 carry into bank
    run(4'd7, 24'h000005, 0, 0, 0, 16'h01FE, 8'h12);        // R8
    run(4'd8, 24'h000002, 0, 0, 16'hF000, 16'hFFFF, 8'hFF); // R9 carry, wrap
    run(4'd11, 24'h000010, 16'h1234, 0, 0, 0, 8'h12);       // R13
    // R11: start during fetch ignored
    cyc(1, 4'd3, 24'h000040, 16'h2000, 0, 16'h0001, 0, 8'h01, 0);
    cyc(1, 4'd5, 24'hABCDEF, 0, 0, 0, 0, 0, 1);
    cyc(1, 4'd0, 24'h000001, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    // mixed random traffic with stalled reads
    for (int k = 0; k < 4000; k++)
      cyc(($urandom % 3) == 0, 4'($urandom), 24'($urandom), 16'($urandom), 16'($urandom),
          16'($urandom), 16'($urandom), 8'($urandom), ($urandom % 2) == 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #1000000;
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule